// File: doc/BRIEF.md
# SMBus host status register

This block holds the eight-bit status register of an SMBus host controller and drives its interrupt request. The transaction engine reports events as single-cycle pulses: a block byte moved, a command that finished cleanly, a host kill, a bus collision, and any of several device error sources. The block latches each pulse into a sticky flag that software clears by writing one. It also samples an external alert input into a flag that only the resume-domain reset or software can clear. It mirrors the engine's busy level into bit 0.

Bit 6 is an ownership semaphore for software threads. The first read after reset returns 0 and claims the controller. Every later read returns 1 until the owner writes 1 to the bit. The register port uses one-cycle read and write strobes. Read data is combinational and is valid during the read strobe. The state change that a read causes takes effect at the clock edge that ends the strobe.

Top module: `smb_host_status`

## Requirements
- R1: After the main reset (`rst_ni` low) bits 7, 6, 4, 3, 2 and 1 read 0. After the resume reset (`rsm_rst_ni` low) bit 5 reads 0.
- R2: A write strobe clears, at the end of that cycle, every bit among 7..1 whose write-data bit is 1. Bits written with 0 keep their value.
- R3: When a set event and a write-one clear hit the same bit in the same cycle, the bit ends up 1.
- R4: Bit 6 reads as its current value during a read strobe and is 1 after that strobe. A write with data bit 6 = 1 makes it 0. A read and such a write in the same cycle leave it at 1.
- R5: Bit 7 sets on a `byte_done_i` pulse unless `heartbeat_i` is high in the same cycle.
- R6: Bit 5 sets in any cycle where `alert_i` is 1 and `alert_gpio_i` is 0. It never sets while `alert_gpio_i` is 1.
- R7: Bit 5 keeps its value through the main reset. Only the resume reset or a write of 1 clears it.
- R8: Bit 4 sets on `kill_i`. Bit 3 sets on `collision_i`. Bit 2 sets when any bit of `dev_err_i` is 1.
- R9: Bit 1 sets on `cmd_done_i` whatever the value of `intr_en_i`.
- R10: Bit 0 equals `busy_i` in the same cycle. Writes do not affect it.
- R11: `irq_o` is 1 exactly when bit 5 is set, or when `intr_en_i` is 1 and any of bits 4..1 is set. It drops in the cycle after the write that clears the last active source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Main reset, asynchronous, active low |
| rsm_rst_ni | input | 1 | Resume-domain reset for the alert flag, asynchronous, active low |
| reg_rd_i | input | 1 | Read strobe for the register, one cycle |
| reg_wr_i | input | 1 | Write strobe for the register, one cycle |
| reg_wdata_i | input | 8 | Write data; ones clear the matching flags |
| reg_rdata_o | output | 8 | Current register value |
| intr_en_i | input | 1 | Interrupt enable for bits 4..1 |
| byte_done_i | input | 1 | Block byte transferred pulse |
| heartbeat_i | input | 1 | Current byte belongs to a heartbeat transmission |
| cmd_done_i | input | 1 | Successful command termination pulse |
| kill_i | input | 1 | Host transaction killed pulse |
| collision_i | input | 1 | Bus collision pulse |
| dev_err_i | input | DEV_SRC_N | Device error sources (illegal command, unclaimed cycle, timeout) |
| alert_i | input | 1 | Synchronized alert pin, active high |
| alert_gpio_i | input | 1 | Alert pin configured as general-purpose I/O |
| busy_i | input | 1 | Engine busy level |
| irq_o | output | 1 | Interrupt request |

## Verification
An event pulse in cycle N shows on `reg_rdata_o` from cycle N+1. A write-one clear in cycle N takes effect in cycle N+1, and so does the semaphore claim made by a read in cycle N. Bit 0 and `irq_o` follow their sources combinationally within the same cycle. The bench queues each expected read value before it raises the read strobe. A monitor pops the value at the falling edge inside the strobe cycle, so every stimulus has passed at least one rising edge before its result is sampled. Interrupt checks run one time step after the rising edge that ends the stimulus.

// File: rtl/smb_stat_pkg.sv
package smb_stat_pkg;
  localparam int STS_W  = 8;
  localparam int B_BUSY = 0;
  localparam int B_DONE = 1;
  localparam int B_DEV  = 2;
  localparam int B_BUS  = 3;
  localparam int B_FAIL = 4;
  localparam int B_ALRT = 5;
  localparam int B_SEM  = 6;
  localparam int B_BYTE = 7;
endpackage

// File: rtl/smb_sts_flag.sv
// sticky flag: set has priority over write-one clear
module smb_sts_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R3
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  // R2
  clr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/smb_irq_merge.sv
module smb_irq_merge #(
  parameter int GATED_W = 4
) (
  input  logic [GATED_W-1:0] gated_i,
  input  logic               ungated_i,
  input  logic               en_i,
  output logic               irq_o
);
  always_comb irq_o = ungated_i | (en_i & (|gated_i));
endmodule

// File: rtl/smb_host_status.sv
module smb_host_status
  import smb_stat_pkg::*;
#(
  parameter int DEV_SRC_N = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rsm_rst_ni,
  input  logic                 reg_rd_i,
  input  logic                 reg_wr_i,
  input  logic [STS_W-1:0]     reg_wdata_i,
  output logic [STS_W-1:0]     reg_rdata_o,
  input  logic                 intr_en_i,
  input  logic                 byte_done_i,
  input  logic                 heartbeat_i,
  input  logic                 cmd_done_i,
  input  logic                 kill_i,
  input  logic                 collision_i,
  input  logic [DEV_SRC_N-1:0] dev_err_i,
  input  logic                 alert_i,
  input  logic                 alert_gpio_i,
  input  logic                 busy_i,
  output logic                 irq_o
);
  localparam int GATED_W = B_ALRT - B_DONE;

  logic [STS_W-1:1] set_v;
  logic [STS_W-1:1] clr_v;
  logic [STS_W-1:1] sts_q;
  logic             unused_wd0;

  assign unused_wd0 = reg_wdata_i[B_BUSY];

  always_comb begin
    set_v         = '0;
    set_v[B_DONE] = cmd_done_i;
    set_v[B_DEV]  = |dev_err_i;
    set_v[B_BUS]  = collision_i;
    set_v[B_FAIL] = kill_i;
    set_v[B_ALRT] = alert_i & ~alert_gpio_i;
    set_v[B_SEM]  = reg_rd_i;              // semaphore claimed by a read strobe
    set_v[B_BYTE] = byte_done_i & ~heartbeat_i;
  end

  assign clr_v = {(STS_W-1){reg_wr_i}} & reg_wdata_i[STS_W-1:1];

  for (genvar i = 1; i < STS_W; i++) begin : g_flag
    logic flag_rst_n;
    if (i == B_ALRT) begin : g_rsm
      assign flag_rst_n = rsm_rst_ni;      // survives main reset
    end else begin : g_main
      assign flag_rst_n = rst_ni;
    end
    smb_sts_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (flag_rst_n),
      .set_i  (set_v[i]),
      .clr_i  (clr_v[i]),
      .q_o    (sts_q[i])
    );
  end

  assign reg_rdata_o = {sts_q, busy_i};

  smb_irq_merge #(.GATED_W(GATED_W)) u_irq (
    .gated_i   (sts_q[B_FAIL:B_DONE]),
    .ungated_i (sts_q[B_ALRT]),
    .en_i      (intr_en_i),
    .irq_o     (irq_o)
  );

  // R9
  done_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_done_i |=> reg_rdata_o[B_DONE]);
  // R6
  gpio_alert_chk: assert property (@(posedge clk_i) disable iff (!rsm_rst_ni)
    (alert_gpio_i && !reg_rdata_o[B_ALRT] && !(reg_wr_i && !reg_wdata_i[B_ALRT] && 1'b0))
      |=> !reg_rdata_o[B_ALRT]);
  // R4
  sem_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i |=> reg_rdata_o[B_SEM]);
  // R5
  heartbeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && heartbeat_i && !reg_rdata_o[B_BYTE]) |=> !reg_rdata_o[B_BYTE]);
  // R11
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !rsm_rst_ni)
    (!irq_o && !(|set_v[B_ALRT:B_DONE])) |=> !irq_o || (intr_en_i && !$past(intr_en_i)));
endmodule

// File: tb/tb_smb_host_status.sv
`timescale 1ns/1ps
module tb_smb_host_status;
  logic clk = 0;
  logic rst_n = 0, rsm_rst_n = 0;
  logic rd = 0, wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic en = 0, byte_d = 0, hb = 0, done = 0, kill = 0, col = 0;
  logic [2:0] dev = 0;
  logic alert = 0, gpio = 0, busy = 0;
  logic irq;
  int ntests = 0, nfail = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  smb_host_status dut (
    .clk_i(clk), .rst_ni(rst_n), .rsm_rst_ni(rsm_rst_n),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .intr_en_i(en), .byte_done_i(byte_d), .heartbeat_i(hb), .cmd_done_i(done),
    .kill_i(kill), .collision_i(col), .dev_err_i(dev), .alert_i(alert),
    .alert_gpio_i(gpio), .busy_i(busy), .irq_o(irq)
  );

  // monitor
  always @(negedge clk) begin
    if (rd && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      ntests++;
      if ((rdata & it.mask) !== (it.exp & it.mask)) begin
        nfail++;
        $display("FAIL %s: rdata=%02h expected=%02h mask=%02h", it.tag, rdata, it.exp, it.mask);
      end
    end
  end

  task automatic rd_chk(input logic [7:0] exp, input logic [7:0] mask, input string tag);
    item_t it;
    it.exp = exp; it.mask = mask; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1 rd = 1;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(posedge clk); #1 wr = 1; wdata = d;
    @(posedge clk); #1 wr = 0; wdata = 0;
  endtask

  // e: 0 done,1 kill,2 col,3..5 dev,6 byte,7 heartbeat
  task automatic set_ev(input logic [7:0] e);
    done = e[0]; kill = e[1]; col = e[2]; dev = e[5:3]; byte_d = e[6]; hb = e[7];
  endtask

  task automatic pulse(input logic [7:0] e);
    @(posedge clk); #1 set_ev(e);
    @(posedge clk); #1 set_ev(8'h00);
  endtask

  task automatic wr_pulse(input logic [7:0] d, input logic [7:0] e);
    @(posedge clk); #1 wr = 1; wdata = d; set_ev(e);
    @(posedge clk); #1 wr = 0; wdata = 0; set_ev(8'h00);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nfail++;
      ntests++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; rsm_rst_n = 1;
    // R1 reset state, R4 first read returns 0
    rd_chk(8'h00, 8'hFF, "R1 reset value");
    rd_chk(8'h40, 8'hFF, "R4 second read claimed");
    wr_reg(8'h40);
    rd_chk(8'h00, 8'h40, "R4 release by write");
    rd_chk(8'h40, 8'h40, "R4 reclaimed");
    // R4 read and release in the same cycle
    @(posedge clk); #1 rd = 1; wr = 1; wdata = 8'h40;
    @(posedge clk); #1 rd = 0; wr = 0; wdata = 0;
    rd_chk(8'h40, 8'h40, "R4 read beats release");

    // R9 completion with interrupt disabled
    en = 0;
    pulse(8'h01);
    rd_chk(8'h02, 8'hBF, "R9 done latched, enable low");
    chk(irq, 1'b0, "R11 gated irq with enable low");
    #1 en = 1; #1;
    chk(irq, 1'b1, "R11 irq with enable high");
    wr_reg(8'h00);
    rd_chk(8'h02, 8'hBF, "R2 write zero keeps bit");
    wr_reg(8'h02);
    chk(irq, 1'b0, "R11 irq drops after clear");
    rd_chk(8'h00, 8'hBF, "R2 clear done");

    // R5 byte done and heartbeat
    pulse(8'h40);
    rd_chk(8'h80, 8'hBF, "R5 byte done");
    wr_reg(8'h80);
    pulse(8'hC0);
    rd_chk(8'h00, 8'hBF, "R5 heartbeat byte ignored");

    // R8 error sources
    pulse(8'h02);
    rd_chk(8'h10, 8'hBF, "R8 kill");
    pulse(8'h04);
    rd_chk(8'h18, 8'hBF, "R8 collision");
    wr_reg(8'h18);
    for (int k = 0; k < 3; k++) begin
      pulse(8'h08 << k);
      rd_chk(8'h04, 8'hBF, "R8 device error source");
      wr_reg(8'h04);
    end
    rd_chk(8'h00, 8'hBF, "R2 all errors cleared");

    // R3 set wins over clear
    pulse(8'h02);
    wr_pulse(8'h12, 8'h01);
    rd_chk(8'h02, 8'hBF, "R3 set beats clear, other bit cleared");
    wr_reg(8'h02);
    en = 0;

    // R6 alert under GPIO mode
    @(posedge clk); #1 gpio = 1; alert = 1;
    repeat (3) @(posedge clk);
    #1 alert = 0;
    rd_chk(8'h00, 8'hBF, "R6 alert blocked in gpio mode");
    chk(irq, 1'b0, "R6 no irq in gpio mode");
    gpio = 0;
    @(posedge clk); #1 alert = 1;
    @(posedge clk); #1 alert = 0;
    rd_chk(8'h20, 8'hBF, "R6 alert latched");
    chk(irq, 1'b1, "R11 alert irq ungated");

    // R7 alert survives main reset
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    rd_chk(8'h20, 8'hFF, "R7 alert kept, R1 others reset");
    @(posedge clk); #1 rsm_rst_n = 0;
    @(posedge clk); #1 rsm_rst_n = 1;
    rd_chk(8'h00, 8'hBF, "R7 resume reset clears alert");

    // R10 busy mirror
    #1 busy = 1;
    rd_chk(8'h01, 8'hBF, "R10 busy mirrored");
    wr_reg(8'h01);
    rd_chk(8'h01, 8'hBF, "R10 write ignored");
    busy = 0;
    rd_chk(8'h00, 8'hBF, "R10 busy cleared");

    repeat (2) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule